// File: doc/BRIEF.md
# ADC Result Buffer Readout Port

This block holds a small bank of signed conversion results and lets a host processor read them through one 16-bit data word. The converter side writes each 14-bit two's-complement result into a numbered slot. The host never writes slots. It loads a slot pointer, then reads.

The read word is presented combinationally from the current pointer. It is shaped by an alignment mode bit. In the right-justified form the sample occupies the low bits and the sign is copied upward. In the left-justified form the sample occupies the high bits and the low bits are zero. Each accepted read strobe moves the pointer to the next slot, so a burst of reads walks through the buffer without reloading the pointer.

A config-select input steers the read word to a configuration view supplied from outside the block. While it is high, strobes do not move the pointer.

Top module: `adc_result_port`

## Requirements
- R1: Synchronous active-high reset sets the pointer to 0 and clears every one of the 25 slots to 0.
- R2: A converter write (`cnv_we`=1) stores `cnv_value` in slot `cnv_slot` at the clock edge. A write to a slot number of 25 or above changes nothing. No host input alters slot contents.
- R3: With `cfg_sel`=0 and `left_just`=0, `rd_word[13:0]` equals the sample and `rd_word[15:14]` both equal sample bit 13.
- R4: With `cfg_sel`=0 and `left_just`=1, `rd_word[15:2]` equals the sample and `rd_word[1:0]` are 0.
- R5: A read strobe (`rd_stb`=1) with `cfg_sel`=0 and no pointer load advances `ptr` by one at that clock edge.
- R6: A read strobe at pointer 24 sets the pointer to 0.
- R7: A pointer value from 25 to 31 makes the sample read as 0, and a read strobe there sets the pointer to 0.
- R8: With `cfg_sel`=1, `rd_word` equals `cfg_view`, and a read strobe leaves the pointer unchanged.
- R9: A pointer load (`ptr_we`=1) in the same cycle as a read strobe takes effect, and the strobe's advance is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnv_we | input | 1 | Converter write enable |
| cnv_slot | input | 5 | Converter write slot number |
| cnv_value | input | 14 | Converter result, two's complement |
| ptr_we | input | 1 | Host pointer load |
| ptr_wdata | input | 5 | Host pointer value |
| rd_stb | input | 1 | Host read strobe, one per read |
| cfg_sel | input | 1 | 1 selects the configuration view, 0 selects the buffer |
| left_just | input | 1 | 1 gives left-justified data, 0 gives right-justified data |
| cfg_view | input | 16 | Configuration word shown when cfg_sel=1 |
| rd_word | output | 16 | Read data word |
| ptr | output | 5 | Current slot pointer |

## Verification
The hardest state to reach is a pointer value between 25 and 31. A walk of strobes never produces one, because the walk wraps at 24. The bench reaches it only through a direct pointer load. It then confirms a zero sample there, and a return to slot 0 on the next strobe.

A similar difficulty is the collision of a pointer load with a strobe. The bench drives both in one cycle and checks that the loaded value lands with no extra step.

Ignored slot writes are exposed by walking all 25 slots against a bench-side model after a write to slot 30.

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;

  // Justification of the sample inside the read word
  typedef enum logic {
    JUST_RIGHT = 1'b0,
    JUST_LEFT  = 1'b1
  } just_e;

endpackage

// File: rtl/adc_slot_store.sv
module adc_slot_store #(
  parameter int SLOTS    = 25,
  parameter int SAMPLE_W = 14,
  parameter int IDX_W    = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_slot,
  input  logic [SAMPLE_W-1:0] wr_value,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [SAMPLE_W-1:0] rd_value
);

  logic [SAMPLE_W-1:0] slot_q [SLOTS];

  // One register per slot; the reset clear rules out a RAM macro
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_q[g] <= '0;
      end else if (wr_en && (wr_slot == IDX_W'(g))) begin
        slot_q[g] <= wr_value;
      end
    end
  end

  // Pointer values past the last slot match nothing and read as zero
  always_comb begin
    rd_value = '0;
    for (int s = 0; s < SLOTS; s++) begin
      if (rd_idx == IDX_W'(s)) rd_value = slot_q[s];
    end
  end

endmodule

// File: rtl/adc_read_index.sv
module adc_read_index #(
  parameter int SLOTS = 25,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic             advance,
  output logic [IDX_W-1:0] idx_q
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  logic [IDX_W-1:0] idx_d;

  always_comb begin
    idx_d = idx_q;
    if (host_we) begin
      idx_d = host_idx;
    end else if (advance) begin
      idx_d = (idx_q >= LAST) ? '0 : idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= idx_d;
  end

endmodule

// File: rtl/adc_align_fmt.sv
module adc_align_fmt
  import adc_rb_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int DATA_W   = 16
) (
  input  logic [SAMPLE_W-1:0] sample,
  input  just_e               mode,
  output logic [DATA_W-1:0]   word
);

  localparam int PAD = DATA_W - SAMPLE_W;

  always_comb begin
    if (mode == JUST_LEFT) word = {sample, {PAD{1'b0}}};
    else                   word = {{PAD{sample[SAMPLE_W-1]}}, sample};
  end

endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
  import adc_rb_pkg::*;
#(
  parameter int SLOTS    = 25,
  parameter int SAMPLE_W = 14,
  parameter int DATA_W   = 16,
  parameter int IDX_W    = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cnv_we,
  input  logic [IDX_W-1:0]    cnv_slot,
  input  logic [SAMPLE_W-1:0] cnv_value,
  input  logic                ptr_we,
  input  logic [IDX_W-1:0]    ptr_wdata,
  input  logic                rd_stb,
  input  logic                cfg_sel,
  input  logic                left_just,
  input  logic [DATA_W-1:0]   cfg_view,
  output logic [DATA_W-1:0]   rd_word,
  output logic [IDX_W-1:0]    ptr
);

  logic [SAMPLE_W-1:0] sample;
  logic [DATA_W-1:0]   fmt_word;
  logic                data_read;
  just_e               mode;

  assign data_read = rd_stb && !cfg_sel;
  assign mode      = just_e'(left_just);

  adc_slot_store #(
    .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst(rst),
    .wr_en(cnv_we), .wr_slot(cnv_slot), .wr_value(cnv_value),
    .rd_idx(ptr), .rd_value(sample)
  );

  adc_read_index #(
    .SLOTS(SLOTS), .IDX_W(IDX_W)
  ) u_index (
    .clk(clk), .rst(rst),
    .host_we(ptr_we), .host_idx(ptr_wdata),
    .advance(data_read), .idx_q(ptr)
  );

  adc_align_fmt #(
    .SAMPLE_W(SAMPLE_W), .DATA_W(DATA_W)
  ) u_fmt (
    .sample(sample), .mode(mode), .word(fmt_word)
  );

  assign rd_word = cfg_sel ? cfg_view : fmt_word;

endmodule

// File: rtl/adc_result_port_chk.sv
module adc_result_port_chk #(
  parameter int SLOTS  = 25,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              ptr_we,
  input logic [IDX_W-1:0]  ptr_wdata,
  input logic              rd_stb,
  input logic              cfg_sel,
  input logic              left_just,
  input logic [DATA_W-1:0] cfg_view,
  input logic [DATA_W-1:0] rd_word,
  input logic [IDX_W-1:0]  ptr
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(SLOTS - 1);

  a_r1_ptr_reset: assert property (@(posedge clk) rst |=> ptr == '0);

  a_r3_sign_copy: assert property (@(posedge clk) disable iff (rst)
    (!cfg_sel && !left_just) |-> (rd_word[DATA_W-1:DATA_W-2] == {2{rd_word[DATA_W-3]}}));

  a_r4_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (!cfg_sel && left_just) |-> (rd_word[1:0] == 2'b00));

  a_r5_step: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !cfg_sel && !ptr_we && ptr < LAST) |=> ptr == $past(ptr) + 1'b1);

  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !cfg_sel && !ptr_we && ptr >= LAST) |=> ptr == '0);

  a_r7_oob_zero: assert property (@(posedge clk) disable iff (rst)
    (!cfg_sel && ptr > LAST) |-> rd_word == '0);

  a_r8_view: assert property (@(posedge clk) disable iff (rst)
    cfg_sel |-> rd_word == cfg_view);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!ptr_we && (!rd_stb || cfg_sel)) |=> $stable(ptr));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (rst)
    ptr_we |=> ptr == $past(ptr_wdata));

endmodule

bind adc_result_port adc_result_port_chk #(
  .SLOTS(SLOTS), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
  .rd_stb(rd_stb), .cfg_sel(cfg_sel), .left_just(left_just),
  .cfg_view(cfg_view), .rd_word(rd_word), .ptr(ptr)
);

// File: tb/test_adc_result_port.sv
module test_adc_result_port;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnv_we = 1'b0;
  logic [4:0]  cnv_slot = '0;
  logic [13:0] cnv_value = '0;
  logic        ptr_we = 1'b0;
  logic [4:0]  ptr_wdata = '0;
  logic        rd_stb = 1'b0;
  logic        cfg_sel = 1'b0;
  logic        left_just = 1'b0;
  logic [15:0] cfg_view = '0;
  logic [15:0] rd_word;
  logic [4:0]  ptr;

  int n_chk = 0;
  int n_bad = 0;
  logic [13:0] model [25];

  always #10 clk = ~clk;

  adc_result_port i_adc_result_port (
    .clk(clk), .rst(rst), .cnv_we(cnv_we), .cnv_slot(cnv_slot),
    .cnv_value(cnv_value), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .rd_stb(rd_stb), .cfg_sel(cfg_sel), .left_just(left_just),
    .cfg_view(cfg_view), .rd_word(rd_word), .ptr(ptr)
  );

  // {slot, sample, left_just, expected word}
  localparam logic [35:0] VEC [7] = '{
    {5'd0,  14'h1FFF, 1'b0, 16'h1FFF},
    {5'd1,  14'h2000, 1'b0, 16'hE000},
    {5'd2,  14'h3FFF, 1'b0, 16'hFFFF},
    {5'd3,  14'h0005, 1'b1, 16'h0014},
    {5'd24, 14'h2001, 1'b1, 16'h8004},
    {5'd12, 14'h1234, 1'b1, 16'h48D0},
    {5'd13, 14'h2ABC, 1'b0, 16'hEABC}
  };

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic conv_write(logic [4:0] s, logic [13:0] v);
    cnv_we = 1'b1; cnv_slot = s; cnv_value = v;
    tick();
    cnv_we = 1'b0;
    if (s < 5'd25) model[s] = v;
  endtask

  task automatic load_ptr(logic [4:0] p);
    ptr_we = 1'b1; ptr_wdata = p;
    tick();
    ptr_we = 1'b0;
  endtask

  task automatic strobe();
    rd_stb = 1'b1;
    tick();
    rd_stb = 1'b0;
  endtask

  function automatic logic [15:0] right_word(logic [13:0] v);
    return {{2{v[13]}}, v};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 25; i++) model[i] = '0;
    repeat (2) tick();
    rst = 1'b0;
    #1;
    // R1: reset state
    check("R1 ptr after reset", 32'(ptr), 32'd0);
    check("R1 slot0 after reset", 32'(rd_word), 32'd0);

    // R2 R3 R4: table of writes and formatted reads
    for (int k = 0; k < 7; k++) begin
      conv_write(VEC[k][35:31], VEC[k][30:17]);
      load_ptr(VEC[k][35:31]);
      left_just = VEC[k][16];
      #1;
      check(VEC[k][16] ? "R4 left justified" : "R3 right justified",
            32'(rd_word), 32'(VEC[k][15:0]));
    end
    left_just = 1'b0;

    // R5: strobes walk consecutive slots
    load_ptr(5'd0);
    for (int i = 0; i < 4; i++) begin
      check("R5 walk data", 32'(rd_word), 32'(right_word(model[i])));
      strobe();
      check("R5 ptr step", 32'(ptr), 32'(i + 1));
    end

    // R6: wrap from the last slot
    load_ptr(5'd24);
    check("R6 last slot data", 32'(rd_word), 32'(right_word(model[24])));
    strobe();
    check("R6 wrap to 0", 32'(ptr), 32'd0);

    // R7: out-of-range pointer
    load_ptr(5'd27);
    check("R7 oob reads zero", 32'(rd_word), 32'd0);
    left_just = 1'b1; #1;
    check("R7 oob left reads zero", 32'(rd_word), 32'd0);
    left_just = 1'b0;
    strobe();
    check("R7 oob strobe to 0", 32'(ptr), 32'd0);

    // R8: configuration view blocks buffer access
    load_ptr(5'd5);
    cfg_sel = 1'b1; cfg_view = 16'hA5C3; #1;
    check("R8 view word", 32'(rd_word), 32'hA5C3);
    strobe();
    check("R8 ptr held", 32'(ptr), 32'd5);
    cfg_sel = 1'b0;

    // R9: pointer load beats a strobe in the same cycle
    rd_stb = 1'b1; ptr_we = 1'b1; ptr_wdata = 5'd7;
    tick();
    rd_stb = 1'b0; ptr_we = 1'b0;
    check("R9 load wins", 32'(ptr), 32'd7);

    // R2: writes to a nonexistent slot and host activity leave slots intact
    conv_write(5'd30, 14'h1555);
    load_ptr(5'd0);
    for (int i = 0; i < 25; i++) begin
      check("R2 slot contents", 32'(rd_word), 32'(right_word(model[i])));
      strobe();
    end
    check("R6 walk wrapped", 32'(ptr), 32'd0);

    // R1: a second reset clears every slot
    load_ptr(5'd9);
    rst = 1'b1; tick(); rst = 1'b0; #1;
    check("R1 ptr cleared", 32'(ptr), 32'd0);
    for (int i = 0; i < 25; i++) begin
      check("R1 slot cleared", 32'(rd_word), 32'd0);
      strobe();
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule